// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a first-in first-out buffer addressed entirely by two internal pointers. A producer stores a word by pulsing an active-low write strobe, and a consumer fetches the oldest stored word by pulsing an active-low read strobe. Neither side supplies an address. The two strobes are independent and may be active in the same cycle. Every strobe edge is detected against a registered copy of the strobe in a single system clock domain.

Three active-low status outputs report the fill level: empty, full, and more than half full. They guard the buffer against underflow and overflow. A rewind input moves the read pointer back to location zero and leaves the write pointer alone, so a frame that has already been read can be sent again after an error. The depth is `2**ADDR_W` words. The default build uses 2048 words, and the 8192-word arrangement is `ADDR_W = 13`. Every data bit, including the ninth bit used for parity, passes through the buffer unchanged.

Top module: `retx_fifo`

## Requirements
- R1: While `rstN` is low, both pointers and the fill count clear, `emptyN` is 0, `fullN` is 1, `halfN` is 1 and `dataOut` is 0.
- R2: A write is taken at the clock edge that first samples `wrN` high after it was low. The value on `dataIn` at that edge is stored with all WIDTH bits intact. Words are read back in the order in which they were written.
- R3: At the clock edge that first samples `rdN` low after it was high, `dataOut` loads the word at the read pointer, provided the buffer is not empty. The read pointer and the count advance only at the later edge that samples `rdN` high again.
- R4: `emptyN` is 0 exactly when no word is stored. A read pulse while the buffer is empty leaves `dataOut` unchanged and does not move the read pointer, so the next word written is the next word read.
- R5: `fullN` is 0 exactly when all DEPTH locations hold unread words. A write pulse while the buffer is full is dropped and overwrites nothing.
- R6: `halfN` is 0 exactly when more than DEPTH/2 words are stored, and it returns to 1 when the count falls to DEPTH/2 or fewer.
- R7: The clock edge that first samples `rtN` low after it was high sets the read pointer to zero and keeps the write pointer. The count becomes the number of words written since reset, and the three flags follow that count. Rewind is valid only while fewer than DEPTH words have been written since reset.
- R8: When a read completion and a write commit fall in the same cycle, the count is unchanged. From empty only the write takes effect, and from full only the read takes effect.
- R9: The flags are never contradictory: `emptyN` and `fullN` are never both 0, `halfN` at 0 implies `emptyN` at 1, and `fullN` at 0 implies `halfN` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrN | input | 1 | Write strobe, active low; the rising edge commits |
| rdN | input | 1 | Read strobe, active low; the falling edge presents data and the rising edge advances the pointer |
| rtN | input | 1 | Rewind request, active low; acts on its falling edge |
| dataIn | input | WIDTH | Word to store |
| dataOut | output | WIDTH | Registered word read from the buffer |
| emptyN | output | 1 | Low when the buffer holds no word |
| fullN | output | 1 | Low when every location holds an unread word |
| halfN | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Each strobe edge is seen at the first rising clock edge after the strobe changes. `dataOut`, the pointers, the count and all three flags settle at that same edge, so every result is due exactly one clock edge after the stimulus. The bench changes inputs on falling clock edges and samples results on the next falling edge, one rising edge later, which is where every output has already settled. The R3 split between presenting a word and advancing the pointer is observed by sampling the flags once between the two edges of a read pulse.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  // strobes from the control side to the storage side
  typedef struct packed {
    logic wrEn;    // store dataIn at wrAddr this cycle
    logic rdLoad;  // load the output register from rdAddr this cycle
  } dpStrobe_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter bit ON_RISE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigN,
  output logic hit
);
  logic prevQ;

  // idle level of every strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= sigN;
  end

  generate
    if (ON_RISE) begin : g_rise
      assign hit = sigN & ~prevQ;
    end else begin : g_fall
      assign hit = ~sigN & prevQ;
    end
  endgenerate
endmodule

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              rtN,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output dpStrobe_t         strobes,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfN
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic wrRise, rdRise, rdFall, rtFall;
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count, countNext;
  logic armed;
  logic wrDo, rdDo, rdLoad;

  strobe_edge #(.ON_RISE(1'b1)) wrEdge_i (.clk(clk), .rstN(rstN), .sigN(wrN), .hit(wrRise));
  strobe_edge #(.ON_RISE(1'b1)) rdRiseEdge_i (.clk(clk), .rstN(rstN), .sigN(rdN), .hit(rdRise));
  strobe_edge #(.ON_RISE(1'b0)) rdFallEdge_i (.clk(clk), .rstN(rstN), .sigN(rdN), .hit(rdFall));
  strobe_edge #(.ON_RISE(1'b0)) rtEdge_i (.clk(clk), .rstN(rstN), .sigN(rtN), .hit(rtFall));

  // a full buffer refuses the write even if a read completes alongside it
  assign wrDo   = wrRise && (count != FULL_CNT);
  // a read completes only if its falling edge found data to present
  assign rdDo   = rdRise && armed && (count != '0) && !rtFall;
  assign rdLoad = rdFall && (count != '0) && !rtFall;

  always_comb begin
    if (rtFall) countNext = {1'b0, wrPtr} + CW'(wrDo);
    else        countNext = count + CW'(wrDo) - CW'(rdDo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      armed  <= 1'b0;
      emptyN <= 1'b0;
      fullN  <= 1'b1;
      halfN  <= 1'b1;
    end else begin
      if (wrDo) wrPtr <= wrPtr + 1'b1;
      if (rtFall)    rdPtr <= '0;
      else if (rdDo) rdPtr <= rdPtr + 1'b1;
      if (rtFall)      armed <= 1'b0;
      else if (rdFall) armed <= (count != '0);
      else if (rdRise) armed <= 1'b0;
      count  <= countNext;
      emptyN <= (countNext != '0);
      fullN  <= (countNext != FULL_CNT);
      halfN  <= !(countNext > HALF_CNT);
    end
  end

  assign wrAddr         = wrPtr;
  assign rdAddr         = rdPtr;
  assign strobes.wrEn   = wrDo;
  assign strobes.rdLoad = rdLoad;
endmodule

// File: rtl/retx_fifo_dp.sv
module retx_fifo_dp
  import retx_fifo_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataOut <= '0;
    else if (strobes.rdLoad) dataOut <= mem[rdAddr];
  end
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             rtN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             emptyN,
  output logic             fullN,
  output logic             halfN
);
  dpStrobe_t         strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  retx_fifo_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN)
  );

  retx_fifo_dp #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk #(
  parameter int ADDR_W = 11,
  parameter int WIDTH  = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrN,
  input logic             rdN,
  input logic             rtN,
  input logic [WIDTH-1:0] dataOut,
  input logic             emptyN,
  input logic             fullN,
  input logic             halfN
);
  logic wrQ, rdQ, rtQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ <= 1'b1; rdQ <= 1'b1; rtQ <= 1'b1;
    end else begin
      wrQ <= wrN; rdQ <= rdN; rtQ <= rtN;
    end
  end
  logic wrUp, rdUp, rdDown, rtDown;
  assign wrUp   = wrN & ~wrQ;
  assign rdUp   = rdN & ~rdQ;
  assign rdDown = ~rdN & rdQ;
  assign rtDown = ~rtN & rtQ;

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!emptyN && !fullN));
  // R9
  half_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfN |-> emptyN);
  // R9
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> !halfN);
  // R4
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyN && rdDown && !rtDown) |=> $stable(dataOut));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyN && rdUp && !wrUp && !rtDown) |=> !emptyN);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN && wrUp && !rdUp && !rtDown) |=> !fullN);
endmodule

bind retx_fifo retx_fifo_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
  .dataOut(dataOut), .emptyN(emptyN), .fullN(fullN), .halfN(halfN)
);

// File: tb/retx_fifo_tb_top.sv
module retx_fifo_tb_top;
  localparam int AW = 4;
  localparam int W  = 9;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rstN, wrN, rdN, rtN;
  logic [W-1:0] dataIn, dataOut;
  logic emptyN, fullN, halfN;

  always #2 clk = ~clk; // 250 MHz

  retx_fifo #(.ADDR_W(AW), .WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .wrN(wrN), .rdN(rdN), .rtN(rtN),
    .dataIn(dataIn), .dataOut(dataOut),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN)
  );

  int tests = 0;
  int fails = 0;
  logic [W-1:0] mMem [D];
  int mWr, mRd, mCnt;
  logic [W-1:0] mOut;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkFlags(input string req);
    chk(emptyN == (mCnt != 0), req, "emptyN", emptyN, mCnt != 0);
    chk(fullN == (mCnt != D), req, "fullN", fullN, mCnt != D);
    chk(halfN == !(mCnt > D/2), req, "halfN", halfN, !(mCnt > D/2));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrN = 1'b1; rdN = 1'b1; rtN = 1'b1; dataIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mWr = 0; mRd = 0; mCnt = 0; mOut = '0;
  endtask

  task automatic doWrite(input logic [W-1:0] d);
    @(negedge clk) wrN = 1'b0;
    @(negedge clk) begin wrN = 1'b1; dataIn = d; end
    @(negedge clk);
    if (mCnt != D) begin
      mMem[mWr % D] = d; mWr++; mCnt++;
    end
  endtask

  task automatic doRead();
    bit armed;
    @(negedge clk) rdN = 1'b0;
    @(negedge clk) rdN = 1'b1;
    @(negedge clk);
    armed = (mCnt != 0);
    if (armed) begin
      mOut = mMem[mRd % D]; mRd++; mCnt--;
    end
  endtask

  task automatic doBoth(input logic [W-1:0] d);
    bit armed, wrDo;
    @(negedge clk) begin wrN = 1'b0; rdN = 1'b0; end
    @(negedge clk) begin wrN = 1'b1; rdN = 1'b1; dataIn = d; end
    @(negedge clk);
    armed = (mCnt != 0);
    wrDo  = (mCnt != D);
    if (armed) mOut = mMem[mRd % D];
    if (wrDo) begin mMem[mWr % D] = d; mWr++; end
    if (armed) mRd++;
    mCnt = mCnt + int'(wrDo) - int'(armed);
  endtask

  task automatic doRewind();
    @(negedge clk) rtN = 1'b0;
    @(negedge clk) rtN = 1'b1;
    @(negedge clk);
    mRd = 0; mCnt = mWr;
  endtask

  function automatic logic [W-1:0] pat(input int n, input int i);
    return W'((n * 53 + i * 29 + 7 + (i[0] ? 256 : 0)) % 512);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL all watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    rstN = 1'b0; wrN = 1'b1; rdN = 1'b1; rtN = 1'b1; dataIn = '0;
    doReset();
    // R1 reset state
    chk(emptyN == 1'b0, "R1", "emptyN", emptyN, 0);
    chk(fullN == 1'b1, "R1", "fullN", fullN, 1);
    chk(halfN == 1'b1, "R1", "halfN", halfN, 1);
    chk(dataOut == '0, "R1", "dataOut", dataOut, 0);

    // sweep every fill level 0..D (R2 R4 R5 R6)
    for (int n = 0; n <= D; n++) begin
      doReset();
      for (int i = 0; i < n; i++) begin
        doWrite(pat(n, i));
        chkFlags("R4/R5/R6 fill");
      end
      doWrite(9'h1AA); // dropped when n == D
      chkFlags("R5 extra write");
      while (mCnt > 0) begin
        doRead();
        chk(dataOut == mOut, "R2 order", "dataOut", dataOut, mOut);
        chkFlags("R4/R5/R6 drain");
      end
      doRead(); // read while empty
      chk(dataOut == mOut, "R4 empty read", "dataOut", dataOut, mOut);
      chkFlags("R4 empty read");
      doWrite(pat(n, 99));
      doRead();
      chk(dataOut == pat(n, 99), "R4 pointer held", "dataOut", dataOut, pat(n, 99));
    end

    // R3 present on fall, advance on rise
    doReset();
    doWrite(9'h155);
    @(negedge clk) rdN = 1'b0;
    @(negedge clk);
    chk(dataOut == 9'h155, "R3 on fall", "dataOut", dataOut, 9'h155);
    chk(emptyN == 1'b1, "R3 no advance yet", "emptyN", emptyN, 1);
    rdN = 1'b1;
    @(negedge clk);
    chk(emptyN == 1'b0, "R3 advance on rise", "emptyN", emptyN, 0);
    mCnt = 0; mRd = 1; mOut = 9'h155;

    // R7 rewind after partial read, then continued writes
    doReset();
    for (int i = 0; i < 10; i++) doWrite(pat(200, i));
    for (int i = 0; i < 4; i++) doRead();
    chkFlags("R7 before rewind");
    doRewind();
    chkFlags("R7 after rewind");
    chk(halfN == 1'b0, "R7 count restored", "halfN", halfN, 0);
    doWrite(pat(200, 10));
    for (int i = 0; i <= 10; i++) begin
      doRead();
      chk(dataOut == pat(200, i), "R7 replay", "dataOut", dataOut, pat(200, i));
    end
    chkFlags("R7 drained");

    // R8 simultaneous read and write: empty, middle, full
    doReset();
    doBoth(9'h0F3);
    chk(dataOut == '0, "R8 empty both", "dataOut", dataOut, 0);
    chkFlags("R8 empty both");
    doRead();
    chk(dataOut == 9'h0F3, "R8 empty both write kept", "dataOut", dataOut, 9'h0F3);
    doReset();
    for (int i = 0; i < 5; i++) doWrite(pat(300, i));
    doBoth(9'h1C1);
    chk(dataOut == pat(300, 0), "R8 mid both", "dataOut", dataOut, pat(300, 0));
    chkFlags("R8 mid count kept");
    while (mCnt > 0) begin
      doRead();
      chk(dataOut == mOut, "R8 mid drain", "dataOut", dataOut, mOut);
    end
    doReset();
    for (int i = 0; i < D; i++) doWrite(pat(400, i));
    doBoth(9'h1EE);
    chk(dataOut == pat(400, 0), "R8 full both", "dataOut", dataOut, pat(400, 0));
    chkFlags("R8 full only read");
    while (mCnt > 0) begin
      doRead();
      chk(dataOut == mOut, "R8 full drain", "dataOut", dataOut, mOut);
    end
    chk(dataOut == pat(400, D-1), "R8 full write dropped", "dataOut", dataOut, pat(400, D-1));

    // R9 flags consistent at rest
    chk(!(!emptyN && !fullN), "R9", "empty&full", int'({emptyN, fullN}), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule